// File: doc/BRIEF.md
# Programmable Four-Input Logic Element

This block is a single configurable logic cell for a field-programmable fabric. Its main resource is a sixteen-entry truth table that can realise any Boolean function of four inputs. The four inputs select one stored bit, and that bit is the combinational function value. A sum-and-carry path lets neighbouring cells form ripple adders without using general routing. An AND-cascade stage lets a chain of cells build wide AND gates. A single flip-flop can hold the result, and a mode bit chooses whether the output comes from the flip-flop or directly from the logic.

The cell is configured through a serial chain. While `cfg_en` is high, one configuration bit enters per clock. The chain holds nineteen bits: sixteen truth-table bits and three mode bits. When `cfg_en` is low, the stored configuration does not change. The values on the logic outputs have no meaning while the chain is being loaded.

`cout` and `casc_out` are purely combinational. A row of cells therefore settles within one clock cycle. `rst_n` is asserted asynchronously, and the environment releases it in step with the clock.

Top module: `lut_cell`

## Requirements
- R1: While `rst_n` is low, and after it is released with nothing loaded, the configuration is all zeros and the flip-flop is clear. `dout`, `cout` and `casc_out` all read 0.
- R2: Each rising edge with `cfg_en` high shifts `cfg_bit` into the chain. After 19 shifts, the first bit shifted in sits at position 0. Positions 15..0 are truth-table entries, position 16 selects registered output, position 17 selects arithmetic mode, and position 18 enables the cascade. While `cfg_en` is low, `cfg_bit` has no effect.
- R3: In logic mode, the function value is truth-table entry number `lut_in`, read as an unsigned index.
- R4: In arithmetic mode, the function value is `lut_in[0] ^ lut_in[1] ^ cin`. `lut_in[3:2]` and the truth table do not affect it.
- R5: In arithmetic mode, `cout` is the majority of `lut_in[0]`, `lut_in[1]` and `cin`. In logic mode, `cout` is 0.
- R6: With the cascade enabled, the cell result is the function value ANDed with `casc_in`. With the cascade disabled, `casc_in` has no effect, as if it were 1.
- R7: `casc_out` always equals the combinational cell result, and it follows the inputs without waiting for a clock edge, even in registered mode. In combinational mode, `dout` equals the same result.
- R8: In registered mode, `dout` shows the cell result captured at the last rising edge at which `ce` was high. An edge with `ce` low leaves it unchanged.
- R9: `clr_n` low clears the flip-flop at once, without a clock edge, and keeps it at 0 even while `ce` is high.
- R10: Asserting `rst_n` clears the flip-flop and the configuration together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, first bit lands at position 0 |
| lut_in | input | 4 | Truth-table index, or operand bits in arithmetic mode |
| cin | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade input from the previous cell |
| ce | input | 1 | Flip-flop clock enable |
| clr_n | input | 1 | Asynchronous active-low flip-flop clear |
| dout | output | 1 | Cell output, registered or combinational |
| cout | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade output to the next cell |

## Verification
The bench provokes two conflicts in the same cycle.

The first is between a flip-flop load and a clear. The bench holds `ce` high with a true result at the flip-flop input and pulls `clr_n` low between edges. It then expects `dout` to fall to 0 immediately and to stay at 0 through the next edge. Once the clear is released, the following edge must capture the result again.

The second conflict is between the registered output and the live cascade output. The bench changes `lut_in` after a capture. It then expects `casc_out` to follow the new value at once while `dout` keeps the captured one.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  localparam int LC_K    = 4;
  localparam int LC_ROWS = 1 << LC_K;

  typedef struct packed {
    logic               casc_en;
    logic               arith_en;
    logic               reg_sel;
    logic [LC_ROWS-1:0] truth;
  } lc_cfg_t;

  localparam int LC_CFG_W = $bits(lc_cfg_t);

endpackage

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg
  import lut_cell_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_en,
  input  logic    cfg_bit,
  output lc_cfg_t cfg
);

  localparam int W = LC_CFG_W;

  logic [W-1:0] chain_q;
  logic [W-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (cfg_en) begin
      chain_d = {cfg_bit, chain_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign cfg = lc_cfg_t'(chain_q);

  // R2: the chain only moves while shifting is enabled
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(chain_q));

  // R2: a shifted bit enters at the top of the chain
  a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (chain_q[W-1] == $past(cfg_bit)));

endmodule

// File: rtl/lut_cell_func.sv
module lut_cell_func
  import lut_cell_pkg::*;
(
  input  lc_cfg_t          cfg,
  input  logic [LC_K-1:0]  lut_in,
  input  logic             cin,
  input  logic             casc_in,
  output logic             result,
  output logic             cout
);

  logic table_bit;
  logic op_a;
  logic op_b;
  logic sum_bit;
  logic maj_bit;
  logic func_bit;
  logic casc_gate;

  // truth-table read: the inputs address one stored bit
  assign table_bit = cfg.truth[lut_in];

  // dedicated sum/carry path on the two low inputs
  assign op_a    = lut_in[0];
  assign op_b    = lut_in[1];
  assign sum_bit = op_a ^ op_b ^ cin;
  assign maj_bit = (op_a & op_b) | (op_a & cin) | (op_b & cin);

  always_comb begin
    if (cfg.arith_en) begin
      func_bit = sum_bit;
      cout     = maj_bit;
    end else begin
      func_bit = table_bit;
      cout     = 1'b0;
    end
  end

  // disabled cascade behaves as a constant 1
  assign casc_gate = cfg.casc_en ? casc_in : 1'b1;
  assign result    = func_bit & casc_gate;

endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic ce,
  input  logic d,
  input  logic reg_sel,
  output logic q_out
);

  logic arst_n;
  logic q;
  logic q_d;

  assign arst_n = rst_n & clr_n;

  always_comb begin
    q_d = q;
    if (ce) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

  assign q_out = reg_sel ? q : d;

  // R9: clear dominates any load
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (q == 1'b0));

  // R8: a disabled edge keeps the stored bit
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ce) |=> (!clr_n || (q == $past(q))));

  // R8: an enabled edge captures the input
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ce) |=> (!clr_n || (q == $past(d))));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic [LC_K-1:0] lut_in,
  input  logic            cin,
  input  logic            casc_in,
  input  logic            ce,
  input  logic            clr_n,
  output logic            dout,
  output logic            cout,
  output logic            casc_out
);

  lc_cfg_t cfg;
  logic    result;

  lut_cell_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg     (cfg)
  );

  lut_cell_func u_func (
    .cfg     (cfg),
    .lut_in  (lut_in),
    .cin     (cin),
    .casc_in (casc_in),
    .result  (result),
    .cout    (cout)
  );

  lut_cell_ff u_ff (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .ce      (ce),
    .d       (result),
    .reg_sel (cfg.reg_sel),
    .q_out   (dout)
  );

  assign casc_out = result;

  // R4: plain arithmetic mode shows the sum on the output pin
  a_r4_sum_out: assert property (@(posedge clk) disable iff (!rst_n || cfg_en)
    (cfg.arith_en && !cfg.casc_en && !cfg.reg_sel) |->
      (dout == (lut_in[0] ^ lut_in[1] ^ cin)));

  // R5: logic mode never propagates a carry
  a_r5_no_carry: assert property (@(posedge clk) disable iff (!rst_n || cfg_en)
    !cfg.arith_en |-> !cout);

  // R6: an enabled cascade with a low input forces the result low
  a_r6_casc_kill: assert property (@(posedge clk) disable iff (!rst_n || cfg_en)
    (cfg.casc_en && !casc_in) |-> (!casc_out && (cfg.reg_sel || !dout)));

  // R7: combinational mode output matches the cascade output
  a_r7_comb_match: assert property (@(posedge clk) disable iff (!rst_n || cfg_en)
    !cfg.reg_sel |-> (dout == casc_out));

endmodule

// File: tb/lut_cell_test.sv
module lut_cell_test;
  import lut_cell_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_en;
  logic            cfg_bit;
  logic [LC_K-1:0] lut_in;
  logic            cin;
  logic            casc_in;
  logic            ce;
  logic            clr_n;
  logic            dout;
  logic            cout;
  logic            casc_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_cell uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_bit  (cfg_bit),
    .lut_in   (lut_in),
    .cin      (cin),
    .casc_in  (casc_in),
    .ce       (ce),
    .clr_n    (clr_n),
    .dout     (dout),
    .cout     (cout),
    .casc_out (casc_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // bit i of the vector goes out on shift i
  task automatic load(input logic [15:0] tbl, input logic rsel,
                      input logic arith, input logic casc);
    logic [18:0] v;
    v = {casc, arith, rsel, tbl};
    @(negedge clk);
    ce     = 1'b0;
    cfg_en = 1'b1;
    for (int i = 0; i < 19; i++) begin
      cfg_bit = v[i];
      @(negedge clk);
    end
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 dout in reset", dout, 1'b0);
    chk("R1 cout in reset", cout, 1'b0);
    chk("R1 casc_out in reset", casc_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    lut_in = 4'hF;
    cin = 1'b1;
    @(negedge clk);
    chk("R1 dout after release", dout, 1'b0);
    chk("R1 cout after release", cout, 1'b0);
  endtask

  task automatic t_table(input logic [15:0] tbl);
    load(tbl, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      lut_in = 4'(i);
      cin = 1'b1;
      #1;
      chk("R3 table lookup", dout, tbl[i]);
      chk("R5 no carry in logic mode", cout, 1'b0);
      chk("R7 casc_out follows", casc_out, tbl[i]);
    end
  endtask

  task automatic t_cfg_hold;
    load(16'h0001, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      cfg_bit = 1'b1;
      @(negedge clk);
    end
    cfg_bit = 1'b0;
    lut_in = 4'h0;
    #1;
    chk("R2 order, entry 0", dout, 1'b1);
    lut_in = 4'hF;
    #1;
    chk("R2 cfg_bit ignored when idle", dout, 1'b0);
  endtask

  task automatic t_arith(input logic [15:0] tbl);
    load(tbl, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic a, b, c;
      a = i[0]; b = i[1]; c = i[2];
      lut_in = {2'(i + 1), b, a};
      cin = c;
      #1;
      chk("R4 sum", dout, a ^ b ^ c);
      chk("R5 carry", cout, (a & b) | (a & c) | (b & c));
    end
  endtask

  task automatic t_cascade;
    load(16'hFFFF, 1'b0, 1'b0, 1'b1);
    lut_in = 4'h5;
    casc_in = 1'b0;
    #1;
    chk("R6 cascade low", dout, 1'b0);
    chk("R6 cascade low out", casc_out, 1'b0);
    casc_in = 1'b1;
    #1;
    chk("R6 cascade high", dout, 1'b1);
    chk("R7 cascade chain out", casc_out, 1'b1);
    load(16'hFFFF, 1'b0, 1'b0, 1'b0);
    casc_in = 1'b0;
    #1;
    chk("R6 casc_in ignored when off", dout, 1'b1);
  endtask

  task automatic t_register;
    load(16'h0002, 1'b1, 1'b0, 1'b0);
    clr_n = 1'b1;
    lut_in = 4'h1;
    ce = 1'b1;
    @(negedge clk);
    chk("R8 capture", dout, 1'b1);
    lut_in = 4'h0;
    #1;
    chk("R7 casc_out live in reg mode", casc_out, 1'b0);
    chk("R8 dout keeps captured", dout, 1'b1);
    ce = 1'b0;
    @(negedge clk);
    chk("R8 hold when ce low", dout, 1'b1);
    ce = 1'b1;
    @(negedge clk);
    chk("R8 recapture", dout, 1'b0);
    lut_in = 4'h1;
    @(negedge clk);
    chk("R8 capture before clear", dout, 1'b1);
    clr_n = 1'b0;
    #1;
    chk("R9 async clear", dout, 1'b0);
    @(negedge clk);
    chk("R9 clear beats ce", dout, 1'b0);
    clr_n = 1'b1;
    @(negedge clk);
    chk("R9 capture after clear", dout, 1'b1);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears register", dout, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ce = 1'b0;
    lut_in = 4'h1;
    @(negedge clk);
    chk("R10 reset clears config", casc_out, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
    lut_in  = '0;
    cin     = 1'b0;
    casc_in = 1'b1;
    ce      = 1'b0;
    clr_n   = 1'b1;
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_table(16'hA5C3);
    t_table(16'h8001);
    t_cfg_hold();
    t_arith(16'h0000);
    t_arith(16'hFFFF);
    t_cascade();
    t_register();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule